// File: doc/BRIEF.md
# UART Modem Control and Status Register Slice

This block holds the configuration and status registers of a 16550-style serial port that deal with line format, modem handshake lines and the baud divisor. A synchronous byte-wide register bus reaches them with a 3-bit offset. Each access is a single-cycle request. Read data is registered and is returned one cycle later together with a valid strobe. The block drives four modem outputs (DTR, RTS and two general outputs), samples four modem inputs (CTS, DSR, RI, DCD) through a synchronizer, and shows three transmitter and receiver status bits that come from elsewhere in the port.

A loopback bit in the modem control register lets software test the handshake path without the cable. While loopback is on, the four modem outputs go inactive (low). The upper nibble of modem status is then taken from the modem control bits with a fixed pairing, and the external inputs are ignored. The lower nibble of modem status holds change flags. A modem status read clears them. The divisor latch and the line control byte are brought out as ports for the baud generator and the serial shifter.

Top module: `uart_modem_regs`

## Requirements
- R1: After reset, line control reads 0x03, modem control reads 0x08, line status reads 0x60, modem status reads 0xB0 (with CTS, DSR and DCD high and RI low at the pins), scratch reads 0x00, and `baud_div` is 12.
- R2: A read request (`bus_sel`=1, `bus_we`=0) returns its data on `bus_rdata` with `bus_rvalid`=1 in the next cycle, and `bus_rvalid` is 0 otherwise. Offsets: 2 interrupt identity, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch.
- R3: The scratch register at offset 7 reads back the last byte written to it.
- R4: Modem control keeps written bits 4:0, and its bits 7:5 read as zero. With bit 4 clear, from the cycle after the write `mdm_dtr`, `mdm_rts`, `mdm_out1` and `mdm_out2` equal written bits 0, 1, 2 and 3.
- R5: With modem control bit 4 (loopback) set, all four modem outputs are 0 from the cycle after the write.
- R6: In loopback, modem status bit 5 follows control bit 0, bit 4 follows control bit 1, bit 6 follows control bit 2 and bit 7 follows control bit 3. The input pins have no effect on the read value.
- R7: Without loopback, modem status bits 4, 5, 6 and 7 show the CTS, DSR, RI and DCD pins, `SYNC_STAGES` cycles after a pin changes.
- R8: Modem status bits 0, 1, 2 and 3 are set when the shown CTS, DSR, RI or DCD value changes. A modem status read returns them and then clears them. A change in the same cycle as the clearing read stays set.
- R9: Line status bit 0 is `st_rx_ready`, bit 5 is `st_thr_empty` and bit 6 is `st_tx_idle`, sampled one cycle before the read. Its other bits are 0, and writes to offset 5 are ignored.
- R10: With line control bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes that drive `baud_div`. With it clear, writes to offsets 0 and 1 leave the divisor unchanged.
- R11: Offset 2 always reads 0x01 and ignores writes. Offsets 0 and 1 read 0x00 while line control bit 7 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data returned this cycle |
| pin_cts | input | 1 | Clear-to-send input, asynchronous |
| pin_dsr | input | 1 | Data-set-ready input, asynchronous |
| pin_ri | input | 1 | Ring input, asynchronous |
| pin_dcd | input | 1 | Carrier-detect input, asynchronous |
| mdm_dtr | output | 1 | Terminal-ready output |
| mdm_rts | output | 1 | Request-to-send output |
| mdm_out1 | output | 1 | General modem output 1 |
| mdm_out2 | output | 1 | General modem output 2 |
| st_rx_ready | input | 1 | Receive data available |
| st_thr_empty | input | 1 | Transmit holding register empty |
| st_tx_idle | input | 1 | Transmitter fully idle |
| line_cfg | output | 8 | Current line control byte |
| baud_div | output | 16 | Current baud divisor |

## Verification
The properties assume that the bus is idle during reset and that `bus_addr` and `bus_we` are meaningful only in cycles where `bus_sel` is high. They also assume that a returned read is attributed to the request of the cycle before. The stimulus drives every bus field and status input at the falling edge, holds `bus_sel` low while reset is asserted, and holds the modem pins at the reset pattern until reset ends, so that no change flag is set by the reset release. The stimulus moves the pins only after several idle cycles so that the synchronizer has settled before modem status is read. The one exception is the deliberate back-to-back case in which a loopback write is followed at once by a status read, which exercises the set-over-clear rule.

// File: rtl/uart_mdm_pkg.sv
// Shared offsets, reset values and the loopback pairing for the modem register slice.
// Assumes a 3-bit register offset and byte-wide registers.
package uart_mdm_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIV_LO = 3'd0,
        OFS_DIV_HI = 3'd1,
        OFS_IDENT  = 3'd2,
        OFS_LINE   = 3'd3,
        OFS_MCTL   = 3'd4,
        OFS_LSTAT  = 3'd5,
        OFS_MSTAT  = 3'd6,
        OFS_SCRAT  = 3'd7
    } reg_ofs_e;

    localparam logic [7:0]  LINE_RST   = 8'h03;
    localparam logic [4:0]  MCTL_RST   = 5'h08;
    localparam logic [7:0]  LSTAT_RST  = 8'h60;
    localparam logic [3:0]  MIN_RST    = 4'b1011;  // {dcd, ri, dsr, cts}
    localparam logic [15:0] DIV_RST    = 16'd12;
    localparam logic [7:0]  IDENT_VAL  = 8'h01;

    localparam int MC_LOOP = 4;
    localparam int LINE_DLAB = 7;

    // Loopback pairing: returns {dcd, ri, dsr, cts} from modem control bits 3:0.
    function automatic logic [3:0] loop_pairs(input logic [3:0] mc);
        return {mc[3], mc[2], mc[0], mc[1]};
    endfunction

endpackage

// File: rtl/uart_pin_sync.sv
// Multi-stage synchronizer for a group of asynchronous inputs.
// Assumes each bit is independent; STAGES >= 1. Reset loads RST_VAL into every stage.
module uart_pin_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/uart_mstat.sv
// Builds the modem status byte: upper nibble from pins or loopback pairing,
// lower nibble from change flags that clear on a status read.
// Assumes rd_clr pulses for one cycle per status read.
module uart_mstat
    import uart_mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pins_sync,   // {dcd, ri, dsr, cts}
    input  logic       loop_en,
    input  logic [3:0] mctl_lo,
    input  logic       rd_clr,
    output logic [7:0] mstat
);

    logic [3:0] shown;
    logic [3:0] shown_q;
    logic [3:0] chg_q;

    // Select the source for the status nibble.
    always_comb begin
        shown = loop_en ? loop_pairs(mctl_lo) : pins_sync;
    end

    // Track the last shown value and accumulate change flags; a new change beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shown_q <= MIN_RST;
            chg_q   <= '0;
        end else begin
            shown_q <= shown;
            chg_q   <= (rd_clr ? 4'b0 : chg_q) | (shown ^ shown_q);
        end
    end

    assign mstat = {shown, chg_q};

endmodule

// File: rtl/uart_regfile.sv
// Writable registers of the slice: line control, modem control, scratch and divisor latch.
// Assumes wr_en is a single-cycle qualified write strobe.
module uart_regfile
    import uart_mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        line_q,
    output logic [4:0]        mctl_q,
    output logic [7:0]        scr_q,
    output logic [15:0]       div_q
);

    logic dlab;
    assign dlab = line_q[LINE_DLAB];

    // Decode writes into the register that owns the offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= LINE_RST;
            mctl_q <= MCTL_RST;
            scr_q  <= '0;
            div_q  <= DIV_RST;
        end else if (wr_en) begin
            case (reg_ofs_e'(addr))
                OFS_DIV_LO: if (dlab) div_q[7:0]  <= wdata;
                OFS_DIV_HI: if (dlab) div_q[15:8] <= wdata;
                OFS_LINE:   line_q <= wdata;
                OFS_MCTL:   mctl_q <= wdata[4:0];
                OFS_SCRAT:  scr_q  <= wdata;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/uart_modem_regs.sv
// Top of the modem register slice: bus decode, registered read path, line status sampling,
// modem output drive with loopback gating. Assumes a synchronous single-cycle bus.
module uart_modem_regs
    import uart_mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              pin_cts,
    input  logic              pin_dsr,
    input  logic              pin_ri,
    input  logic              pin_dcd,
    output logic              mdm_dtr,
    output logic              mdm_rts,
    output logic              mdm_out1,
    output logic              mdm_out2,
    input  logic              st_rx_ready,
    input  logic              st_thr_empty,
    input  logic              st_tx_idle,
    output logic [7:0]        line_cfg,
    output logic [15:0]       baud_div
);

    logic       wr_en, rd_en, loop_en;
    logic [7:0] line_q, scr_q, lstat_q, mstat;
    logic [4:0] mctl_q;
    logic [15:0] div_q;
    logic [3:0] pins_sync;

    assign wr_en = bus_sel &  bus_we;
    assign rd_en = bus_sel & ~bus_we;

    uart_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .line_q (line_q),
        .mctl_q (mctl_q),
        .scr_q  (scr_q),
        .div_q  (div_q)
    );

    uart_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(MIN_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pin_dcd, pin_ri, pin_dsr, pin_cts}),
        .q_sync  (pins_sync)
    );

    assign loop_en = mctl_q[MC_LOOP];

    uart_mstat u_mstat (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_sync (pins_sync),
        .loop_en   (loop_en),
        .mctl_lo   (mctl_q[3:0]),
        .rd_clr    (rd_en && reg_ofs_e'(bus_addr) == OFS_MSTAT),
        .mstat     (mstat)
    );

    // Sample transmitter and receiver status into the line status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) lstat_q <= LSTAT_RST;
        else        lstat_q <= {1'b0, st_tx_idle, st_thr_empty, 4'b0, st_rx_ready};
    end

    // Registered read path: data and valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) begin
                case (reg_ofs_e'(bus_addr))
                    OFS_DIV_LO: bus_rdata <= line_q[LINE_DLAB] ? div_q[7:0]  : 8'h00;
                    OFS_DIV_HI: bus_rdata <= line_q[LINE_DLAB] ? div_q[15:8] : 8'h00;
                    OFS_IDENT:  bus_rdata <= IDENT_VAL;
                    OFS_LINE:   bus_rdata <= line_q;
                    OFS_MCTL:   bus_rdata <= {3'b000, mctl_q};
                    OFS_LSTAT:  bus_rdata <= lstat_q;
                    OFS_MSTAT:  bus_rdata <= mstat;
                    default:    bus_rdata <= scr_q;
                endcase
            end
        end
    end

    assign mdm_dtr  = mctl_q[0] & ~loop_en;
    assign mdm_rts  = mctl_q[1] & ~loop_en;
    assign mdm_out1 = mctl_q[2] & ~loop_en;
    assign mdm_out2 = mctl_q[3] & ~loop_en;
    assign line_cfg = line_q;
    assign baud_div = div_q;

endmodule

// File: rtl/uart_modem_regs_chk.sv
// Property checker for the modem register slice, bound to the top module.
// Assumes the bus is idle during reset.
module uart_modem_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic [4:0] mc_wr,
    input logic [7:0] bus_rdata,
    input logic       bus_rvalid,
    input logic       mdm_dtr,
    input logic       mdm_rts,
    input logic       mdm_out1,
    input logic       mdm_out2
);

    // R2: read returns a strobe exactly one cycle later
    p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);
    p_rvalid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> !bus_rvalid);

    // R4: non-loop write drives outputs from the written bits
    p_mctl_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 3'd4 && !mc_wr[4]) |=>
        ({mdm_out2, mdm_out1, mdm_rts, mdm_dtr} == $past(mc_wr[3:0])));

    // R4: modem control upper bits read zero
    p_mctl_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 3'd4) |=> (bus_rdata[7:5] == 3'b000));

    // R5: loopback write silences all modem outputs
    p_loop_outputs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 3'd4 && mc_wr[4]) |=>
        !(mdm_dtr || mdm_rts || mdm_out1 || mdm_out2));

    // R9: reserved line status bits read zero
    p_lstat_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 3'd5) |=> ((bus_rdata & 8'h9E) == 8'h00));

    // R11: identity offset constant
    p_ident_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 3'd2) |=> (bus_rdata == 8'h01));

endmodule

bind uart_modem_regs uart_modem_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .mc_wr      (bus_wdata[4:0]),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .mdm_dtr    (mdm_dtr),
    .mdm_rts    (mdm_rts),
    .mdm_out1   (mdm_out1),
    .mdm_out2   (mdm_out2)
);

// File: tb/tb_uart_modem_regs.sv
`timescale 1ns/1ps
module tb_uart_modem_regs;

    localparam real PERIOD = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic        pin_cts = 1'b1, pin_dsr = 1'b1, pin_ri = 1'b0, pin_dcd = 1'b1;
    logic        mdm_dtr, mdm_rts, mdm_out1, mdm_out2;
    logic        st_rx_ready = 1'b0, st_thr_empty = 1'b1, st_tx_idle = 1'b1;
    logic [7:0]  line_cfg;
    logic [15:0] baud_div;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(PERIOD/2) clk = ~clk;

    uart_modem_regs dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Driver: one write cycle (called at a falling edge).
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Driver: one read cycle, pushes expected data to the scoreboard.
    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each returned read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: actual unexpected read 0x%0h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), {8'h00, bus_rdata}, {8'h00, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state at ports and registers
        check("R1 outputs", {12'h0, mdm_out2, mdm_out1, mdm_rts, mdm_dtr}, 16'h0008);
        check("R1 divisor", baud_div, 16'd12);
        check("R1 line_cfg", {8'h0, line_cfg}, 16'h0003);
        rd(3'd3, 8'h03, "R1 line");
        rd(3'd4, 8'h08, "R1 mctl");
        rd(3'd5, 8'h60, "R1 lstat");
        rd(3'd6, 8'hB0, "R1 mstat");
        rd(3'd7, 8'h00, "R1 scratch");
        rd(3'd2, 8'h01, "R11 ident");
        rd(3'd0, 8'h00, "R11 ofs0");
        rd(3'd1, 8'h00, "R11 ofs1");

        // R3 scratch
        wr(3'd7, 8'hA5); rd(3'd7, 8'hA5, "R3 scratch A5");
        wr(3'd7, 8'h5A); rd(3'd7, 8'h5A, "R3 scratch 5A");

        // R4 modem control storage and drive
        wr(3'd4, 8'hE3);
        check("R4 outputs", {12'h0, mdm_out2, mdm_out1, mdm_rts, mdm_dtr}, 16'h0003);
        rd(3'd4, 8'h03, "R4 mctl readback");
        wr(3'd4, 8'h0C);
        check("R4 outputs b", {12'h0, mdm_out2, mdm_out1, mdm_rts, mdm_dtr}, 16'h000C);

        // R7 / R8 pin path and change flags
        pin_cts = 1'b0; idle(5);
        rd(3'd6, 8'hA1, "R7 R8 cts fall");
        rd(3'd6, 8'hA0, "R8 cleared");
        pin_ri = 1'b1; pin_dcd = 1'b0; idle(5);
        rd(3'd6, 8'h6C, "R7 R8 ri dcd");
        rd(3'd6, 8'h60, "R8 cleared b");

        // R5 / R6 loopback
        wr(3'd4, 8'h1A);
        check("R5 outputs low", {12'h0, mdm_out2, mdm_out1, mdm_rts, mdm_dtr}, 16'h0000);
        idle(1);
        rd(3'd6, 8'h9F, "R6 R8 loop entry");
        rd(3'd6, 8'h90, "R6 loop steady");
        pin_cts = 1'b1; pin_dsr = 1'b0; idle(5);
        rd(3'd6, 8'h90, "R6 pins ignored");
        rd(3'd4, 8'h1A, "R4 loop readback");
        pin_dsr = 1'b1; idle(5);

        // leave loopback: pins cts1 dsr1 ri1 dcd0
        wr(3'd4, 8'h00); idle(1);
        rd(3'd6, 8'h7E, "R7 R8 loop exit");
        rd(3'd6, 8'h70, "R8 cleared c");

        // R8 change in same cycle as clearing read
        wr(3'd4, 8'h11);
        rd(3'd6, 8'h20, "R8 same-cycle read");
        rd(3'd6, 8'h25, "R8 set beats clear");
        rd(3'd6, 8'h20, "R8 cleared d");
        check("R5 loop dtr low", {15'h0, mdm_dtr}, 16'h0000);
        wr(3'd4, 8'h00);

        // R9 line status
        st_rx_ready = 1'b1; st_thr_empty = 1'b0; st_tx_idle = 1'b0; idle(2);
        rd(3'd5, 8'h01, "R9 lstat sample");
        wr(3'd5, 8'hFF);
        rd(3'd5, 8'h01, "R9 lstat write ignored");
        st_rx_ready = 1'b0; st_thr_empty = 1'b1; st_tx_idle = 1'b1; idle(2);
        rd(3'd5, 8'h60, "R9 lstat restore");

        // R10 divisor latch
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0, 8'h34, "R10 div lo");
        rd(3'd1, 8'h12, "R10 div hi");
        check("R10 baud_div", baud_div, 16'h1234);
        rd(3'd3, 8'h83, "R10 line dlab");
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h55);
        wr(3'd1, 8'h66);
        rd(3'd0, 8'h00, "R11 ofs0 no dlab");
        idle(1);
        check("R10 divisor kept", baud_div, 16'h1234);

        // R11 identity ignores writes
        wr(3'd2, 8'hFF);
        rd(3'd2, 8'h01, "R11 ident after write");

        idle(3);
        check("R2 scoreboard drained", {8'h0, 8'(exp_q.size())}, 16'h0000);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule